// File: doc/BRIEF.md
# Processor exception entry sequencer

This block performs the entry half of exception handling for a 32-bit RISC core. Execution and memory units raise one-cycle requests on an eight-bit request vector. The block merges them into a pending vector that it holds internally. Each cycle it picks the most urgent eligible request. For that request it computes the saved program counter, the saved status word, the next machine state register (MSR) value and the handler address. It registers all four results together with a one-cycle taken strobe. It also retires the chosen request from the pending vector.

The surrounding core copies `msr_out` into its MSR and the two save values into its save/restore registers. On the cycle after `taken` is high, it steers fetch to `redirect_pc`. The MSR, the current PC and the next PC are plain level inputs that are sampled in the selection cycle. There is no back-pressure. A taken exception is a strobe that the core must accept, and requests that the block cannot take yet stay pending rather than being refused.

Top module: `exc_entry_seq`

## Requirements
- R1: Request bit positions are 0 fetch-translation fault, 1 program/trap, 2 system call, 3 FPU unavailable, 4 data fault, 5 alignment, 6 external interrupt, 7 decrementer. The lowest eligible pending index is taken first.
- R2: At most one exception is taken per cycle. A request sampled at a clock edge can be taken at the following edge. The taken bit leaves the pending vector, and every other pending bit is kept.
- R3: `save_stat` equals `msr_in & 0x87C0FFFF`. The value 0x40000000 is ORed in for index 0, and 0x00040000 is ORed in for index 1.
- R4: `msr_out` is `msr_in` with bit 16 ORed into bit 0, after which the bits of 0x0004EF36 are cleared.
- R5: `redirect_pc` is 0x80000400, 0x80000700, 0x80000C00, 0x80000800, 0x80000300, 0x80000600, 0x80000500 or 0x80000900 for indices 0 to 7 respectively.
- R6: `save_pc` is `nxt_pc` for indices 0, 2, 6 and 7, and `cur_pc` for indices 1, 3, 4 and 5. For index 0, `nxt_pc` carries the faulting fetch address.
- R7: Indices 6 and 7 are eligible only while `msr_in` bit 15 is 1. While that bit is 0 they stay pending and are never taken. The other indices ignore that bit.
- R8: A request that arrives in the same cycle its index is taken leaves that bit pending, so it is taken again.
- R9: Synchronous active-high `rst` clears the pending vector, `taken` and all result outputs to zero.
- R10: In a cycle with no exception taken, `taken` is 0 and `msr_out`, `save_pc`, `save_stat` and `redirect_pc` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 8 | One-cycle exception requests, indexed as in R1 |
| cur_pc | input | 32 | Address of the instruction in flight |
| nxt_pc | input | 32 | Next sequential address, or the faulting fetch address |
| msr_in | input | 32 | Current machine state register |
| taken | output | 1 | One-cycle strobe: an exception was entered |
| msr_out | output | 32 | MSR value to install on entry |
| save_pc | output | 32 | Value for the saved-PC register |
| save_stat | output | 32 | Value for the saved-status register |
| redirect_pc | output | 32 | Handler address for fetch |

## Verification
A request driven before edge N joins the pending vector at N. Its entry is registered at edge N+1, and each lower-priority request follows one edge later. The bench therefore drives inputs on falling edges and checks every result on the falling edge that follows each rising edge. For each cycle, it predicts from the request pattern and the external-enable bit which index is due, and checks all four results against that index. Eligible requests in all 256 patterns, with external enable set and cleared, drain in priority order. Held-over interrupts, same-cycle re-requests and the hold behaviour of idle cycles are checked at the exact cycle in which they become visible.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN    = 32;
  localparam int NUM_EXC = 8;
  localparam int IDX_W   = $clog2(NUM_EXC);

  typedef enum logic [IDX_W-1:0] {
    EX_IFETCH = 3'd0,
    EX_PROG   = 3'd1,
    EX_SYSC   = 3'd2,
    EX_FPU    = 3'd3,
    EX_DATA   = 3'd4,
    EX_ALIGN  = 3'd5,
    EX_EXT    = 3'd6,
    EX_DEC    = 3'd7
  } exc_e;

  localparam logic [XLEN-1:0] STAT_KEEP  = 32'h87C0_FFFF;
  localparam logic [XLEN-1:0] STAT_FETCH = 32'h4000_0000;
  localparam logic [XLEN-1:0] STAT_TRAP  = 32'h0004_0000;
  localparam logic [XLEN-1:0] MSR_CLEAR  = 32'h0004_EF36;
  localparam logic [XLEN-1:0] VEC_BASE   = 32'h8000_0000;
  localparam int EE_POS  = 15;
  localparam int ILE_POS = 16;
  localparam int LE_POS  = 0;

  // Indices that are masked by the external-enable bit
  localparam logic [NUM_EXC-1:0] ASYNC_MASK = 8'b1100_0000;

  function automatic logic [XLEN-1:0] vec_offset(exc_e c);
    case (c)
      EX_IFETCH: return 32'h0400;
      EX_PROG:   return 32'h0700;
      EX_SYSC:   return 32'h0C00;
      EX_FPU:    return 32'h0800;
      EX_DATA:   return 32'h0300;
      EX_ALIGN:  return 32'h0600;
      EX_EXT:    return 32'h0500;
      default:   return 32'h0900;
    endcase
  endfunction

  function automatic logic saves_next(exc_e c);
    return (c == EX_IFETCH) || (c == EX_SYSC) || (c == EX_EXT) || (c == EX_DEC);
  endfunction

  function automatic logic [XLEN-1:0] stat_extra(exc_e c);
    case (c)
      EX_IFETCH: return STAT_FETCH;
      EX_PROG:   return STAT_TRAP;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_pending.sv
module exc_pending
  import exc_pkg::*;
#(
  parameter int N = NUM_EXC,
  parameter logic [N-1:0] AMASK = ASYNC_MASK
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req_set,
  input  logic                 async_en,
  output logic                 take_valid,
  output logic [$clog2(N)-1:0] take_idx,
  output logic [N-1:0]         take_vec
);
  localparam int W = $clog2(N);

  logic [N-1:0] pend;
  logic [N-1:0] elig;

  assign elig = pend & (async_en ? {N{1'b1}} : ~AMASK);

  // lowest index wins: scan from top, last hit overrides
  always_comb begin
    take_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) take_idx = W'(i);
    end
  end

  assign take_valid = |elig;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_vec
      assign take_vec[g] = take_valid && (take_idx == W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~take_vec) | req_set;
  end

  // R2: bits not taken remain pending
  p_lower_kept_r2: assert property (@(posedge clk) disable iff (rst)
    take_valid |=> ((pend & $past(pend & ~take_vec)) == $past(pend & ~take_vec)));

  // R8: taken bit clears unless re-requested in that same cycle
  p_clear_or_reset_r8: assert property (@(posedge clk) disable iff (rst)
    take_valid |=> ((pend & $past(take_vec)) == ($past(req_set) & $past(take_vec))));

  // R7: masked interrupts never selected
  p_async_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !async_en |-> ((take_vec & AMASK) == '0));

  // R1: nothing of higher priority was eligible
  p_priority_r1: assert property (@(posedge clk) disable iff (rst)
    take_valid |-> ((elig & (take_vec - 1'b1)) == '0));
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_pkg::*;
(
  input  exc_e            cause,
  input  logic [XLEN-1:0] msr_cur,
  output logic [XLEN-1:0] msr_next,
  output logic [XLEN-1:0] stat
);
  logic [XLEN-1:0] le_merged;

  always_comb begin
    le_merged         = msr_cur;
    le_merged[LE_POS] = msr_cur[LE_POS] | msr_cur[ILE_POS];
    msr_next          = le_merged & ~MSR_CLEAR;
    stat              = (msr_cur & STAT_KEEP) | stat_extra(cause);
  end
endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_pkg::*;
(
  input  exc_e            cause,
  input  logic [XLEN-1:0] pc_cur,
  input  logic [XLEN-1:0] pc_nxt,
  output logic [XLEN-1:0] pc_save,
  output logic [XLEN-1:0] vector
);
  assign pc_save = saves_next(cause) ? pc_nxt : pc_cur;
  assign vector  = VEC_BASE | vec_offset(cause);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EXC-1:0]  req_set,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic [XLEN-1:0]     nxt_pc,
  input  logic [XLEN-1:0]     msr_in,
  output logic                taken,
  output logic [XLEN-1:0]     msr_out,
  output logic [XLEN-1:0]     save_pc,
  output logic [XLEN-1:0]     save_stat,
  output logic [XLEN-1:0]     redirect_pc
);
  logic               tv;
  logic [IDX_W-1:0]   tidx;
  logic [NUM_EXC-1:0] tvec;
  exc_e               cause;
  logic [XLEN-1:0]    msr_n, stat_n, psave_n, vec_n;

  exc_pending #(.N(NUM_EXC), .AMASK(ASYNC_MASK)) u_pend (
    .clk(clk), .rst(rst), .req_set(req_set), .async_en(msr_in[EE_POS]),
    .take_valid(tv), .take_idx(tidx), .take_vec(tvec)
  );

  assign cause = exc_e'(tidx);

  exc_state_calc u_state (
    .cause(cause), .msr_cur(msr_in), .msr_next(msr_n), .stat(stat_n)
  );

  exc_target_calc u_tgt (
    .cause(cause), .pc_cur(cur_pc), .pc_nxt(nxt_pc),
    .pc_save(psave_n), .vector(vec_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken       <= 1'b0;
      msr_out     <= '0;
      save_pc     <= '0;
      save_stat   <= '0;
      redirect_pc <= '0;
    end else begin
      taken <= tv;
      if (tv) begin
        msr_out     <= msr_n;
        save_pc     <= psave_n;
        save_stat   <= stat_n;
        redirect_pc <= vec_n;
      end
    end
  end

  // R4: cleared bits are zero after entry
  p_msr_cleared_r4: assert property (@(posedge clk) disable iff (rst)
    taken |-> ((msr_out & MSR_CLEAR) == '0));

  // R3: only kept bits plus the two cause flags may appear
  p_stat_bits_r3: assert property (@(posedge clk) disable iff (rst)
    taken |-> ((save_stat & ~(STAT_KEEP | STAT_FETCH | STAT_TRAP)) == '0));

  // R5: handler address lies in the vector page on a 256-byte slot
  p_vector_page_r5: assert property (@(posedge clk) disable iff (rst)
    taken |-> (redirect_pc[31:12] == 20'h80000 && redirect_pc[7:0] == 8'h00));

  // R7: interrupt vectors only entered with external enable set
  p_ee_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (taken && (redirect_pc == 32'h8000_0500 || redirect_pc == 32'h8000_0900))
      |-> $past(msr_in[EE_POS]));

  // R10: results hold when nothing is entered
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!taken && !$past(rst)) |-> ($stable(redirect_pc) && $stable(save_pc)));
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req_set = '0;
  logic [31:0] cur_pc = '0, nxt_pc = '0, msr_in = '0;
  logic        taken;
  logic [31:0] msr_out, save_pc, save_stat, redirect_pc;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst(rst), .req_set(req_set), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
    .msr_in(msr_in), .taken(taken), .msr_out(msr_out), .save_pc(save_pc),
    .save_stat(save_stat), .redirect_pc(redirect_pc)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] e_vec(int i);
    logic [31:0] off [8] = '{32'h400, 32'h700, 32'hC00, 32'h800,
                             32'h300, 32'h600, 32'h500, 32'h900};
    return 32'h8000_0000 + off[i];
  endfunction

  function automatic logic [31:0] e_msr(logic [31:0] m);
    logic [31:0] t;
    t = m | {31'b0, m[16]};
    return t & ~32'h0004_EF36;
  endfunction

  function automatic logic [31:0] e_stat(int i, logic [31:0] m);
    logic [31:0] s;
    s = m & 32'h87C0_FFFF;
    if (i == 0) s = s + 32'h4000_0000;
    if (i == 1) s = s + 32'h0004_0000;
    return s;
  endfunction

  function automatic logic [31:0] e_save(int i, logic [31:0] c, logic [31:0] n);
    return (i == 0 || i == 2 || i == 6 || i == 7) ? n : c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_set = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(taken == 1'b0, "R9 taken", {31'b0, taken}, 32'h0);
    chk(redirect_pc == 32'h0 && save_pc == 32'h0 && save_stat == 32'h0 && msr_out == 32'h0,
        "R9 outputs", redirect_pc | save_pc | save_stat | msr_out, 32'h0);
  endtask

  task automatic check_entry(int i, string tag);
    chk(taken == 1'b1, {tag, " R2 strobe"}, {31'b0, taken}, 32'h1);
    chk(redirect_pc == e_vec(i), {tag, " R1/R5 vector"}, redirect_pc, e_vec(i));
    chk(save_pc == e_save(i, cur_pc, nxt_pc), {tag, " R6 save_pc"}, save_pc,
        e_save(i, cur_pc, nxt_pc));
    chk(save_stat == e_stat(i, msr_in), {tag, " R3 save_stat"}, save_stat, e_stat(i, msr_in));
    chk(msr_out == e_msr(msr_in), {tag, " R4 msr"}, msr_out, e_msr(msr_in));
  endtask

  task automatic run_pattern(logic [7:0] pat, logic ee);
    logic [7:0]  rem;
    logic [31:0] l_pc, l_vec, l_st, l_msr;
    logic        any;
    do_reset();
    msr_in = {pat, ~pat, pat, pat} ^ 32'h5A3C_16E1;
    msr_in[15] = ee;
    cur_pc = 32'h0010_0000 + {22'b0, pat, 2'b00};
    nxt_pc = 32'h0020_0000 + {22'b0, pat, 2'b00} + 32'd4;
    req_set = pat;
    @(negedge clk);
    req_set = '0;
    rem = pat;
    any = 1'b0;
    for (int k = 0; k < 10; k++) begin
      int sel;
      @(negedge clk);
      sel = -1;
      for (int j = 7; j >= 0; j--) if (rem[j] && (j < 6 || ee)) sel = j;
      if (sel < 0) begin
        chk(taken == 1'b0, "R2/R7 idle", {31'b0, taken}, 32'h0);
        if (any) begin
          chk(save_pc == l_pc && redirect_pc == l_vec && save_stat == l_st && msr_out == l_msr,
              "R10 hold", redirect_pc, l_vec);
        end
        break;
      end
      check_entry(sel, $sformatf("pat=%02h ee=%0d", pat, ee));
      rem[sel] = 1'b0;
      any = 1'b1;
      l_pc = save_pc; l_vec = redirect_pc; l_st = save_stat; l_msr = msr_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1..R7, R10: sweep every request pattern with EE clear and set
    for (int p = 0; p < 256; p++) begin
      run_pattern(8'(p), 1'b0);
      run_pattern(8'(p), 1'b1);
    end

    // R7: held external interrupt is taken once EE becomes 1
    do_reset();
    msr_in = 32'h0001_0002; cur_pc = 32'h100; nxt_pc = 32'h104;
    req_set = 8'h40;
    @(negedge clk);
    req_set = '0;
    @(negedge clk);
    chk(taken == 1'b0, "R7 masked", {31'b0, taken}, 32'h0);
    @(negedge clk);
    chk(taken == 1'b0, "R7 still masked", {31'b0, taken}, 32'h0);
    msr_in = 32'h0001_8002;
    @(negedge clk);
    check_entry(6, "R7 released");

    // R8: re-request in the cycle of its own entry keeps it pending
    do_reset();
    msr_in = 32'h0000_8000; cur_pc = 32'h200; nxt_pc = 32'h204;
    req_set = 8'h06;
    @(negedge clk);
    req_set = 8'h02;
    @(negedge clk);
    req_set = '0;
    check_entry(1, "R8 first");
    @(negedge clk);
    check_entry(1, "R8 again");
    @(negedge clk);
    check_entry(2, "R8 lower");

    // R9: reset mid-stream drops pending requests
    do_reset();
    req_set = 8'h0F;
    @(negedge clk);
    req_set = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(taken == 1'b0, "R9 pending dropped", {31'b0, taken}, 32'h0);
    @(negedge clk);
    chk(taken == 1'b0, "R9 pending dropped later", {31'b0, taken}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule